// File: doc/BRIEF.md
# Paged memory protection checker

This block sits beside a CPU-local memory region and checks every access to it against a table of per-page permissions. The region has a base and a size that are set by parameters. It is split into 32 equal pages. Each page has one permission entry. The entry holds separate user and supervisor bits for read, write and execute, plus a local-access flag.

An access is described by an address, a kind (fetch, load or store) and a privilege level. If the access falls inside the region and its page does not grant the one permission the access needs, the block raises a one-cycle fault event. It also records the address and the permission that was missing.

Software works with the block through a small word-indexed register port. On this port it programs the permission entries, reads the fault record and clears it. The entry index space is 64 wide. Only 32 consecutive entries are implemented, starting at a parameterised index. The lowest page of the region is governed by that first implemented entry.

Top module: `mpc_page_guard`

## Requirements
- R1: An address A with BASE <= A < BASE+SIZE is in page p = (A-BASE)/(SIZE/32). Page p is governed by permission entry ENTRY_BASE+p. That entry is reached at register index ENTRY_BASE+p. Defaults: BASE=0x00A00000, SIZE=0x80000, ENTRY_BASE=16, so each page is 0x4000 bytes.
- R2: A permission entry is 7 bits wide. The bits are: bit0 user execute, bit1 user write, bit2 user read, bit3 supervisor execute, bit4 supervisor write, bit5 supervisor read, bit6 local. A read returns these bits with bits 31:7 zero.
- R3: After reset every implemented entry reads 0x7F. Both fault registers read zero, and no access faults until an entry is changed.
- R4: acc_kind_i selects the required permission: 0 = fetch needs execute, 1 = load needs read, 2 = store needs write, 3 = no requirement. The bit is taken from the user set when acc_sup_i=0 and from the supervisor set when acc_sup_i=1. An access violates when that bit is clear in its page's entry.
- R5: fault_o is high for exactly the one cycle after a violating access is sampled on acc_valid_i. It is low otherwise.
- R6: On a fault with no record held, register index 64 captures the access address. Register index 65 bits 5:0 capture the missing permission bits, in the bit positions of R2.
- R7: While a record is held, a further fault leaves indices 64 and 65 bits 5:0 unchanged and sets the sticky overflow bit, index 65 bit 16.
- R8: Writing index 65 with bit0=1 clears the fault address, the missing bits and the overflow flag. A fault in the same cycle as the clear is recorded as a first fault.
- R9: Writes to entry indices outside ENTRY_BASE..ENTRY_BASE+31 are ignored, and reads of them return zero. The same holds for writes to index 64.
- R10: Accesses outside BASE..BASE+SIZE-1 are never checked and never fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 none |
| acc_sup_i | input | 1 | 1 = supervisor, 0 = user |
| fault_o | output | 1 | Protection fault event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
A check of an access is due one clock edge after the cycle in which acc_valid_i is high. The fault record reaches the register port at that same edge. The bench drives inputs on the falling edge and samples fault_o shortly after the next rising edge. It then samples again one edge later to prove the pulse has ended.

Register writes take effect at the rising edge that follows the strobe. Reads are combinational, so the bench sets the index on a falling edge and compares a moment later. Both the overflow case and the clear case are checked through reads at index 65, made between accesses.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int PERM_W = 7;
  localparam int B_UX = 0;
  localparam int B_UW = 1;
  localparam int B_UR = 2;
  localparam int B_SX = 3;
  localparam int B_SW = 4;
  localparam int B_SR = 5;
  localparam int B_LOC = 6;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  function automatic logic [5:0] need_bits(acc_kind_e kind, logic sup);
    logic [2:0] u;
    case (kind)
      ACC_FETCH: u = 3'b001;
      ACC_STORE: u = 3'b010;
      ACC_LOAD:  u = 3'b100;
      default:   u = 3'b000;
    endcase
    return sup ? {u, 3'b000} : {3'b000, u};
  endfunction
endpackage

// File: rtl/mpc_page_decode.sv
module mpc_page_decode #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h00A0_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0008_0000,
  parameter int                PAGES       = 32,
  localparam int               PG_W        = $clog2(PAGES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [PG_W-1:0]   page_o
);
  localparam int SHIFT = $clog2(REGION_SIZE) - PG_W;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr_i - REGION_BASE;
    // offset compare also covers base+size wrapping the address space
    hit_o  = (addr_i >= REGION_BASE) && (offset < REGION_SIZE);
    page_o = offset[SHIFT +: PG_W];
  end
endmodule

// File: rtl/mpc_perm_file.sv
module mpc_perm_file
  import mpc_pkg::*;
#(
  parameter int  PAGES      = 32,
  parameter int  IDX_W      = 6,
  parameter int  ENTRY_BASE = 16,
  localparam int PG_W       = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PERM_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PERM_W-1:0] rd_data_o,
  input  logic [PG_W-1:0]   page_i,
  output logic [PERM_W-1:0] page_perm_o
);
  logic [PERM_W-1:0] perm_q [PAGES];

  for (genvar p = 0; p < PAGES; p++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        perm_q[p] <= '1;
      end else if (wr_en_i && wr_idx_i == IDX_W'(ENTRY_BASE + p)) begin
        perm_q[p] <= wr_data_i;
      end
    end
  end

  logic [IDX_W-1:0] rd_off;
  logic             rd_hit;

  always_comb begin
    rd_off      = rd_idx_i - IDX_W'(ENTRY_BASE);
    rd_hit      = (rd_idx_i >= IDX_W'(ENTRY_BASE)) && (rd_off < IDX_W'(PAGES));
    rd_data_o   = rd_hit ? perm_q[rd_off[PG_W-1:0]] : '0;
    page_perm_o = perm_q[page_i];
  end
endmodule

// File: rtl/mpc_fault_rec.sv
module mpc_fault_rec #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              viol_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [5:0]        miss_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [5:0]        miss_o,
  output logic              ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      miss_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (clr_i) begin
        valid_o <= 1'b0;
        addr_o  <= '0;
        miss_o  <= '0;
        ovf_o   <= 1'b0;
      end
      if (viol_i) begin
        if (!valid_o || clr_i) begin
          valid_o <= 1'b1;
          addr_o  <= addr_i;
          miss_o  <= miss_i;
        end else begin
          ovf_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mpc_page_guard.sv
module mpc_page_guard
  import mpc_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h00A0_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0008_0000,
  parameter int                PAGES       = 32,
  parameter int                IDX_SPACE   = 64,
  parameter int                ENTRY_BASE  = 16,
  localparam int               IDX_W       = $clog2(IDX_SPACE),
  localparam int               REG_AW      = IDX_W + 1,
  localparam int               PG_W        = $clog2(PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              acc_sup_i,
  output logic              fault_o,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  localparam logic [REG_AW-1:0] IDX_FADDR = REG_AW'(IDX_SPACE);
  localparam logic [REG_AW-1:0] IDX_FSTAT = REG_AW'(IDX_SPACE + 1);

  logic              in_region;
  logic [PG_W-1:0]   page;
  logic [PERM_W-1:0] page_perm;
  logic [PERM_W-1:0] rd_perm;
  logic [5:0]        need, miss;
  logic              viol;
  logic              perm_we, clr_stat;
  logic              rec_valid, rec_ovf;
  logic [ADDR_W-1:0] rec_addr;
  logic [5:0]        rec_miss;

  mpc_page_decode #(
    .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE),
    .REGION_SIZE(REGION_SIZE), .PAGES(PAGES)
  ) u_dec (
    .addr_i(acc_addr_i), .hit_o(in_region), .page_o(page)
  );

  assign perm_we  = reg_we_i && !reg_addr_i[REG_AW-1];
  assign clr_stat = reg_we_i && (reg_addr_i == IDX_FSTAT) && reg_wdata_i[0];

  mpc_perm_file #(
    .PAGES(PAGES), .IDX_W(IDX_W), .ENTRY_BASE(ENTRY_BASE)
  ) u_perm (
    .clk_i, .rst_ni,
    .wr_en_i(perm_we), .wr_idx_i(reg_addr_i[IDX_W-1:0]),
    .wr_data_i(reg_wdata_i[PERM_W-1:0]),
    .rd_idx_i(reg_addr_i[IDX_W-1:0]), .rd_data_o(rd_perm),
    .page_i(page), .page_perm_o(page_perm)
  );

  always_comb begin
    need = need_bits(acc_kind_e'(acc_kind_i), acc_sup_i);
    miss = need & ~page_perm[5:0];
    viol = acc_valid_i && in_region && (|miss);
  end

  mpc_fault_rec #(.ADDR_W(ADDR_W)) u_rec (
    .clk_i, .rst_ni,
    .viol_i(viol), .addr_i(acc_addr_i), .miss_i(miss), .clr_i(clr_stat),
    .valid_o(rec_valid), .addr_o(rec_addr), .miss_o(rec_miss), .ovf_o(rec_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= viol;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (!reg_addr_i[REG_AW-1])       reg_rdata_o = 32'(rd_perm);
    else if (reg_addr_i == IDX_FADDR) reg_rdata_o = 32'(rec_addr);
    else if (reg_addr_i == IDX_FSTAT) reg_rdata_o = {15'd0, rec_ovf, 10'd0, rec_miss};
  end
endmodule

// File: rtl/mpc_page_guard_chk.sv
module mpc_page_guard_chk #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h00A0_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0008_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              fault_o,
  input logic              clr_stat,
  input logic              rec_valid,
  input logic              rec_ovf,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [5:0]        rec_miss
);
  logic outside;
  assign outside = (acc_addr_i < REGION_BASE) ||
                   ((acc_addr_i - REGION_BASE) >= REGION_SIZE);

  a_r5_pulse_follows_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_valid_i));

  a_r10_outside_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && outside |=> !fault_o);

  a_r6_fault_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> rec_valid && (rec_miss != 6'd0));

  a_r7_record_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid && !clr_stat |=> $stable(rec_addr) && $stable(rec_miss));

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ovf && !clr_stat |=> rec_ovf);

  a_r8_clear_drops_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stat |=> !rec_ovf);
endmodule

bind mpc_page_guard mpc_page_guard_chk #(
  .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i),
  .acc_addr_i(acc_addr_i), .fault_o(fault_o), .clr_stat(clr_stat),
  .rec_valid(rec_valid), .rec_ovf(rec_ovf), .rec_addr(rec_addr),
  .rec_miss(rec_miss)
);

// File: tb/tb_mpc_page_guard.sv
module tb_mpc_page_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_kind_i = '0;
  logic        acc_sup_i = 1'b0;
  logic        fault_o;
  logic        reg_we_i = 1'b0;
  logic [6:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  mpc_page_guard dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i); reg_addr_i = a; #1;
    chk(reg_rdata_o, exp, tag);
  endtask

  // drive one access; check the pulse in the following cycle and its end
  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic s,
                     input logic exp, input string tag);
    @(negedge clk_i); acc_valid_i = 1'b1; acc_addr_i = a; acc_kind_i = k; acc_sup_i = s;
    @(posedge clk_i); #1;
    chk(32'(fault_o), 32'(exp), tag);
    @(negedge clk_i); acc_valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk(32'(fault_o), 32'd0, {tag, " pulse end R5"});
  endtask

  task automatic t_reset;
    #1 chk(32'(fault_o), 0, "R3 fault_o in reset");
    rd(7'd16, 32'h7F, "R3 entry16 reset");
    rd(7'd47, 32'h7F, "R3 entry47 reset");
    rd(7'd64, 32'h0, "R3 faddr reset");
    rd(7'd65, 32'h0, "R3 fstat reset");
    acc(32'h00A4_0000, 2'd2, 1'b0, 1'b0, "R3 no fault at reset");
  endtask

  task automatic t_unimpl;
    wr(7'd5, 32'h0);
    rd(7'd5, 32'h0, "R9 unimpl entry5 reads 0");
    rd(7'd48, 32'h0, "R9 unimpl entry48 reads 0");
    rd(7'd16, 32'h7F, "R9 entry16 untouched");
    acc(32'h00A0_0000, 2'd0, 1'b0, 1'b0, "R9 write to entry5 no effect");
    wr(7'd64, 32'hDEAD_BEEF);
    rd(7'd64, 32'h0, "R9 faddr write ignored");
  endtask

  task automatic t_first_fault;
    wr(7'd16, 32'hFFFF_FF7E);
    rd(7'd16, 32'h7E, "R2 entry16 readback");
    acc(32'h00A0_0010, 2'd1, 1'b0, 1'b0, "R4 user load allowed");
    acc(32'h00A0_0010, 2'd0, 1'b0, 1'b1, "R4 R5 user fetch faults");
    rd(7'd64, 32'h00A0_0010, "R6 fault address");
    rd(7'd65, 32'h01, "R6 missing UX");
  endtask

  task automatic t_overflow;
    acc(32'h00A0_0020, 2'd0, 1'b0, 1'b1, "R7 second fault pulses");
    rd(7'd64, 32'h00A0_0010, "R7 address held");
    rd(7'd65, 32'h0001_0001, "R7 overflow set, miss held");
  endtask

  task automatic t_clear;
    wr(7'd65, 32'h1);
    rd(7'd65, 32'h0, "R8 status cleared");
    rd(7'd64, 32'h0, "R8 address cleared");
  endtask

  task automatic t_priv_boundary;
    wr(7'd47, 32'h6D); // no SW, no UW
    acc(32'h00A7_FFFC, 2'd1, 1'b0, 1'b0, "R1 last page user load ok");
    acc(32'h00A7_FFFC, 2'd2, 1'b1, 1'b1, "R4 sup store faults");
    rd(7'd65, 32'h10, "R6 missing SW");
    rd(7'd64, 32'h00A7_FFFC, "R1 last page addr");
    wr(7'd65, 32'h1);
    acc(32'h00A7_BFFC, 2'd2, 1'b1, 1'b0, "R1 page 30 unaffected");
    acc(32'h00A7_FFFC, 2'd3, 1'b1, 1'b0, "R4 kind none no check");
  endtask

  task automatic t_outside;
    wr(7'd16, 32'h0);
    acc(32'h009F_FFFC, 2'd0, 1'b0, 1'b0, "R10 below base");
    acc(32'h00A8_0000, 2'd1, 1'b1, 1'b0, "R10 at end");
    rd(7'd65, 32'h0, "R10 no record");
    acc(32'h00A0_0000, 2'd1, 1'b0, 1'b1, "R1 first byte page0");
    rd(7'd65, 32'h04, "R6 missing UR");
    wr(7'd16, 32'h40);
    rd(7'd16, 32'h40, "R2 local bit readback");
  endtask

  task automatic t_clear_with_fault;
    // entry16 = 0x40; record held from t_outside
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 7'd65; reg_wdata_i = 32'h1;
    acc_valid_i = 1'b1; acc_addr_i = 32'h00A0_0100; acc_kind_i = 2'd2; acc_sup_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b0; acc_valid_i = 1'b0;
    rd(7'd65, 32'h10, "R8 fault with clear recorded fresh");
    rd(7'd64, 32'h00A0_0100, "R8 fault with clear address");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_unimpl();
    t_first_fault();
    t_overflow();
    t_clear();
    t_priv_boundary();
    t_outside();
    t_clear_with_fault();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i); cyc++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule